// File: doc/BRIEF.md
# SPI Slave Port with Selectable Chip-Select Source

This block is the receiving end of a four-wire SPI link. An external master drives the serial clock, the MOSI data line and an active-low chip select. The block shifts one frame in and one frame out at the same time. The serial clock, MOSI and the chip select are resampled into the system clock domain through a two-stage synchroniser, and clock edges are found there.

Two configuration inputs choose one of the four clock-polarity and clock-phase modes. Two more set the frame size to 8 or 16 bits and the bit order. A local bus on the system side loads the next outgoing word and collects the last received word. The three buffer flags are transmit-empty, receive-full and overrun.

The chip select can come from the pin. It can also come from an internal level input that firmware drives, and in that case the pin has no effect. MISO is released (its output enable is low) whenever the port is not selected. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_tgt`

## Requirements
- R1: With `sw_sel_en_i`=1, the select level is taken from `sw_sel_ni` (0 = selected) and `cs_ni` is ignored. This covers both the output enable and any clocking on `sck_i`. With `sw_sel_en_i`=0, the select level is taken from `cs_ni` (0 = selected).
- R2: `sdo_oe_o` is 1 exactly while the port is selected and 0 otherwise, so MISO is tri-stated when the port is idle.
- R3: `cpol_i` gives the idle level of `sck_i`. The leading edge is the first transition away from that level. With `cpha_i`=0, the first data bit is presented on `sdo_o` as soon as select becomes active, with no clock edge. MOSI is sampled on each leading edge, and the next MISO bit is presented on each trailing edge.
- R4: With `cpha_i`=1, each MISO bit, including the first, is presented on a leading edge, and MOSI is sampled on each trailing edge.
- R5: With `wide_i`=0, a frame is 8 bits. It sends `wr_data_i[7:0]`, and the received word appears in `rd_data_o[7:0]` with bits 15:8 zero. With `wide_i`=1, a frame is 16 bits and uses the full word.
- R6: With `lsb_first_i`=0, bit 7 (or bit 15) travels first. With `lsb_first_i`=1, bit 0 travels first. The same order applies in both directions.
- R7: When the last bit of a frame is sampled, `rxne_o` rises and `rd_data_o` shows the word. A pulse on `rd_en_i` clears `rxne_o`.
- R8: `txe_o` is 1 after reset. A pulse on `wr_en_i` stores `wr_data_i` and clears `txe_o`. `txe_o` returns to 1 when the stored word is copied into the shifter at the start of a frame.
- R9: If a frame completes while `rxne_o` is still 1 and no read happens in that cycle, `ovr_o` rises and `rd_data_o` keeps the older word. A read clears `ovr_o`.
- R10: If select goes inactive before a frame is complete, the partial bits are dropped, `rxne_o` is not set, and the next frame starts again from its first bit.
- R11: If `txe_o` is still 1 when a new frame starts, the port sends the last written word again. This also applies to back-to-back frames within one select period.
- R12: `sck_i`, `sdi_i` and `cs_ni` each pass through two synchroniser flops. A change on `cs_ni` reaches `sdo_oe_o` after exactly two `clk_i` rising edges. The visible outputs follow a cycle-by-cycle model with that pin latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| wide_i | input | 1 | 0: 8-bit frame; 1: 16-bit frame |
| lsb_first_i | input | 1 | 1: bit 0 travels first |
| sw_sel_en_i | input | 1 | 1: select taken from `sw_sel_ni` instead of the pin |
| sw_sel_ni | input | 1 | Internal select level, active low |
| sck_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Chip select pin, active low |
| sdi_i | input | 1 | Serial data in (MOSI) |
| sdo_o | output | 1 | Serial data out (MISO) |
| sdo_oe_o | output | 1 | Output enable for MISO |
| wr_en_i | input | 1 | Load transmit buffer |
| wr_data_i | input | 16 | Word to transmit |
| rd_en_i | input | 1 | Read strobe for the receive buffer |
| rd_data_o | output | 16 | Last received word |
| txe_o | output | 1 | Transmit buffer empty |
| rxne_o | output | 1 | Receive buffer holds an unread word |
| ovr_o | output | 1 | A completed word was lost |

## Verification
The bench builds the port with its defaults: a 16-bit maximum frame, an 8-bit narrow frame and two synchroniser stages. It clocks the link with eight system cycles per serial half period. With the 16-bit maximum, frames of both sizes can be exercised, and every bit position of the wide frame is reachable in either order. With eight cycles per half period, the three-cycle pin-to-output delay fits inside each half period with margin. This lets a behavioural model follow the exact cycle in which each flag and each MISO bit changes, in all four clock modes and for both select sources.

// File: rtl/spi_tgt_pkg.sv
`timescale 1ns/1ps
package spi_tgt_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic wide;
    logic lsb_first;
  } spi_cfg_t;
endpackage

// File: rtl/spi_tgt_sync.sv
`timescale 1ns/1ps
module spi_tgt_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
`timescale 1ns/1ps
module spi_tgt_edge
  import spi_tgt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_s_i,
  input  spi_cfg_t cfg_i,
  output logic     sample_o,
  output logic     launch_o
);
  logic sck_q;
  logic toggled, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  assign toggled  = sck_s_i ^ sck_q;
  assign lead     = toggled & (sck_s_i != cfg_i.cpol);
  assign trail    = toggled & (sck_s_i == cfg_i.cpol);
  assign sample_o = cfg_i.cpha ? trail : lead;
  assign launch_o = cfg_i.cpha ? lead  : trail;
endmodule

// File: rtl/spi_tgt_shift.sv
`timescale 1ns/1ps
module spi_tgt_shift
  import spi_tgt_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  spi_cfg_t      cfg_i,
  input  logic          sel_i,
  input  logic          sample_i,
  input  logic          launch_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] tx_word_i,
  output logic          load_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          sdo_o
);
  localparam int CW = $clog2(DW);

  logic          sel_q, first_q, miso_q;
  logic [CW-1:0] cnt_q, last_idx;
  logic [DW-1:0] tx_sh_q, tx_aligned, rx_full;
  logic [DW-2:0] rx_sh_q;
  logic          start;

  assign last_idx = cfg_i.wide ? CW'(DW-1) : CW'(NW-1);
  assign start    = sel_i & ~sel_q;
  assign done_o   = sel_i & ~start & sample_i & (cnt_q == last_idx);
  assign load_o   = sel_i & (start ? ~cfg_i.cpha : (launch_i & first_q));
  assign rx_full  = {rx_sh_q, sdi_i};
  assign sdo_o    = miso_q;

  // outgoing word aligned so that bit DW-1 leaves first
  always_comb begin
    tx_aligned = '0;
    for (int i = 0; i < DW; i++) begin
      if (cfg_i.wide)
        tx_aligned[DW-1-i] = cfg_i.lsb_first ? tx_word_i[i] : tx_word_i[DW-1-i];
      else if (i < NW)
        tx_aligned[DW-1-i] = cfg_i.lsb_first ? tx_word_i[i] : tx_word_i[NW-1-i];
    end
  end

  // newest bit sits at rx_full[0]
  always_comb begin
    rx_word_o = '0;
    for (int i = 0; i < DW; i++) begin
      if (cfg_i.wide)
        rx_word_o[i] = cfg_i.lsb_first ? rx_full[DW-1-i] : rx_full[i];
      else if (i < NW)
        rx_word_o[i] = cfg_i.lsb_first ? rx_full[NW-1-i] : rx_full[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      first_q <= 1'b1;
      cnt_q   <= '0;
      rx_sh_q <= '0;
      tx_sh_q <= '0;
      miso_q  <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (!sel_i || start) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (sample_i) begin
        rx_sh_q <= rx_full[DW-2:0];
        if (done_o) begin
          cnt_q   <= '0;
          first_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      if (load_o) begin
        miso_q  <= tx_aligned[DW-1];
        tx_sh_q <= tx_aligned << 1;
        first_q <= 1'b0;
      end else if (sel_i && !start && launch_i) begin
        miso_q  <= tx_sh_q[DW-1];
        tx_sh_q <= tx_sh_q << 1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && sel_q |-> cnt_q <= last_idx); // R5
  AST_DESEL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> cnt_q == '0 && first_q); // R10
  AST_MISO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i && !start |=> $stable(sdo_o)); // R3
  AST_DONE_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> first_q); // R11
endmodule

// File: rtl/spi_tgt_buf.sv
`timescale 1ns/1ps
module spi_tgt_buf #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          load_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_word_i,
  output logic [DW-1:0] tx_word_o,
  output logic [DW-1:0] rd_data_o,
  output logic          txe_o,
  output logic          rxne_o,
  output logic          ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_o <= '0;
      rd_data_o <= '0;
      txe_o     <= 1'b1;
      rxne_o    <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      // a host write in the load cycle wins; the shifter took the old word
      if (wr_en_i) begin
        tx_word_o <= wr_data_i;
        txe_o     <= 1'b0;
      end else if (load_i) begin
        txe_o <= 1'b1;
      end
      if (rd_en_i) ovr_o <= 1'b0;
      if (done_i) begin
        if (rxne_o && !rd_en_i) begin
          ovr_o <= 1'b1;
        end else begin
          rd_data_o <= rx_word_i;
          rxne_o    <= 1'b1;
        end
      end else if (rd_en_i) begin
        rxne_o <= 1'b0;
      end
    end
  end

  AST_TXE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !txe_o); // R8
  AST_RXNE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rxne_o); // R7
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !done_i |=> !rxne_o && !ovr_o); // R7
  AST_OVR_KEEPS_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && rxne_o && !rd_en_i |=> ovr_o && $stable(rd_data_o)); // R9
  AST_OVR_WITH_RXNE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> rxne_o); // R9
endmodule

// File: rtl/spi_tgt.sv
`timescale 1ns/1ps
module spi_tgt
  import spi_tgt_pkg::*;
#(
  parameter int DW          = 16,
  parameter int NW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          wide_i,
  input  logic          lsb_first_i,
  input  logic          sw_sel_en_i,
  input  logic          sw_sel_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          txe_o,
  output logic          rxne_o,
  output logic          ovr_o
);
  spi_cfg_t      cfg;
  logic          sck_s, cs_s, sdi_s, sel;
  logic          sample, launch, load, done;
  logic [DW-1:0] tx_word, rx_word;

  assign cfg = '{cpol: cpol_i, cpha: cpha_i, wide: wide_i, lsb_first: lsb_first_i};

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({sck_i, cs_ni, sdi_i}),
    .q_o ({sck_s, cs_s, sdi_s})
  );

  assign sel      = sw_sel_en_i ? ~sw_sel_ni : ~cs_s;
  assign sdo_oe_o = sel;

  spi_tgt_edge u_edge (
    .clk_i, .rst_ni,
    .sck_s_i  (sck_s),
    .cfg_i    (cfg),
    .sample_o (sample),
    .launch_o (launch)
  );

  spi_tgt_shift #(.DW(DW), .NW(NW)) u_shift (
    .clk_i, .rst_ni,
    .cfg_i     (cfg),
    .sel_i     (sel),
    .sample_i  (sample),
    .launch_i  (launch),
    .sdi_i     (sdi_s),
    .tx_word_i (tx_word),
    .load_o    (load),
    .done_o    (done),
    .rx_word_o (rx_word),
    .sdo_o     (sdo_o)
  );

  spi_tgt_buf #(.DW(DW)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_data_i, .rd_en_i,
    .load_i    (load),
    .done_i    (done),
    .rx_word_i (rx_word),
    .tx_word_o (tx_word),
    .rd_data_o,
    .txe_o, .rxne_o, .ovr_o
  );

  AST_SW_PIN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_sel_en_i && sw_sel_ni |=> !rxne_o || $stable(rd_data_o)); // R1
endmodule

// File: tb/sim_spi_tgt.sv
`timescale 1ns/1ps
module sim_spi_tgt;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cpol = 0, cpha = 0, wide = 0, lsb = 0, sw_en = 0, sw_n = 1;
  logic sck = 0, cs_n = 1, sdi = 0, wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic sdo, sdo_oe, txe, rxne, ovr;
  logic [15:0] rd_data;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  spi_tgt u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .wide_i(wide),
    .lsb_first_i(lsb), .sw_sel_en_i(sw_en), .sw_sel_ni(sw_n), .sck_i(sck),
    .cs_ni(cs_n), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .txe_o(txe),
    .rxne_o(rxne), .ovr_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        pa, pb, pc, sa, sb, sc, ma, mb;
  logic        m_selq, m_first, m_miso, m_txe, m_rxne, m_ovr;
  int          m_cnt, m_idx;
  logic [15:0] m_word, m_rx, m_txbuf, m_rxbuf;

  function automatic logic bit_of(input logic [15:0] w, input int i);
    int len = wide ? 16 : 8;
    if (i >= len) return 1'b0;
    return lsb ? w[i] : w[len-1-i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa = 0; pb = 0; pc = 0; sa = 1; sb = 1; sc = 1; ma = 0; mb = 0;
      m_selq = 0; m_first = 1; m_miso = 0; m_txe = 1; m_rxne = 0; m_ovr = 0;
      m_cnt = 0; m_idx = 0; m_word = 0; m_rx = 0; m_txbuf = 0; m_rxbuf = 0;
    end else begin
      logic selnow, lead, trail, smp, lnc, ld, fin;
      logic [15:0] got, mask;
      int len;
      len   = wide ? 16 : 8;
      mask  = wide ? 16'hFFFF : 16'h00FF;
      selnow = sw_en ? !sw_n : !sb;
      lead  = (pb != pc) && (pb != cpol);
      trail = (pb != pc) && (pb == cpol);
      smp   = cpha ? trail : lead;
      lnc   = cpha ? lead : trail;
      ld = 0; fin = 0; got = 0;
      if (!selnow) begin
        m_cnt = 0; m_first = 1;
      end else if (!m_selq) begin
        m_cnt = 0; m_first = 1;
        if (!cpha) ld = 1;
      end else begin
        if (smp) begin
          if (lsb) m_rx[m_cnt] = mb; else m_rx = (m_rx << 1) | 16'(mb);
          if (m_cnt == len - 1) begin
            fin = 1; got = m_rx & mask; m_cnt = 0; m_first = 1;
          end else m_cnt++;
        end
        if (lnc) begin
          if (m_first) ld = 1;
          else begin m_idx++; m_miso = bit_of(m_word, m_idx); end
        end
      end
      if (ld) begin
        m_word = m_txbuf; m_idx = 0; m_miso = bit_of(m_word, 0); m_first = 0;
      end
      if (wr_en) begin m_txbuf = wr_data; m_txe = 0; end
      else if (ld) m_txe = 1;
      if (rd_en) m_ovr = 0;
      if (fin) begin
        if (m_rxne && !rd_en) m_ovr = 1;
        else begin m_rxbuf = got; m_rxne = 1; end
      end else if (rd_en) m_rxne = 0;
      m_selq = selnow;
      pc = pb; pb = pa; pa = sck;
      sc = sb; sb = sa; sa = cs_n;
      mb = ma; ma = sdi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic eoe;
      eoe = sw_en ? !sw_n : !sb;
      chk((sdo_oe == eoe) && (txe == m_txe) && (rxne == m_rxne) && (ovr == m_ovr)
          && (rd_data == m_rxbuf) && (!eoe || sdo == m_miso),
          "R12", "per-clock model {oe,txe,rxne,ovr,sdo,rd}",
          {sdo_oe, txe, rxne, ovr, sdo, rd_data}, {eoe, m_txe, m_rxne, m_ovr, m_miso, m_rxbuf});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_write(input logic [15:0] v);
    wr_en = 1; wr_data = v; tick(1); wr_en = 0;
  endtask

  task automatic host_read();
    rd_en = 1; tick(1); rd_en = 0;
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic w, input logic l);
    cpol = pol; cpha = pha; wide = w; lsb = l; sck = pol; tick(4);
  endtask

  task automatic sel(input bit on);
    if (sw_en) sw_n = !on; else cs_n = !on;
    tick(H);
  endtask

  task automatic frame(input logic [15:0] v, input int nbits, output logic [15:0] r);
    int len = wide ? 16 : 8;
    r = '0;
    for (int k = 0; k < nbits; k++) begin
      logic b = lsb ? v[k] : v[len-1-k];
      if (!cpha) begin
        sdi = b; tick(H);
        r[lsb ? k : len-1-k] = sdo;
        sck = ~cpol; tick(H);
        sck = cpol;
      end else begin
        sck = ~cpol; sdi = b; tick(H);
        r[lsb ? k : len-1-k] = sdo;
        sck = cpol; tick(H);
      end
    end
    tick(H);
  endtask

  logic [15:0] r1, r2;

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    chk(txe == 1, "R8", "txe after reset", txe, 1);
    chk(rxne == 0, "R7", "rxne after reset", rxne, 0);
    chk(ovr == 0, "R9", "ovr after reset", ovr, 0);
    chk(sdo_oe == 0, "R2", "oe after reset", sdo_oe, 0);

    // mode 0, 8-bit, MSB first, with select latency probe
    set_mode(0, 0, 0, 0);
    host_write(16'h00A5);
    chk(txe == 0, "R8", "txe after write", txe, 0);
    cs_n = 0; tick(1);
    chk(sdo_oe == 0, "R12", "oe one edge after select", sdo_oe, 0);
    tick(1);
    chk(sdo_oe == 1, "R12", "oe two edges after select", sdo_oe, 1);
    tick(H);
    chk(sdo == 1, "R3", "first bit before any clock edge", sdo, 1);
    frame(16'h003C, 8, r1);
    sel(0);
    chk(r1 == 16'h00A5, "R3", "mode0 master received", r1, 16'h00A5);
    chk(rxne == 1, "R7", "rxne after frame", rxne, 1);
    chk(rd_data == 16'h003C, "R7", "mode0 rd_data", rd_data, 16'h003C);
    chk(txe == 1, "R8", "txe after load", txe, 1);
    chk(sdo_oe == 0, "R2", "oe after deselect", sdo_oe, 0);
    host_read();
    chk(rxne == 0, "R7", "rxne after read", rxne, 0);

    // mode 1
    set_mode(0, 1, 0, 0);
    host_write(16'h005A);
    sel(1); frame(16'h00C3, 8, r1); sel(0);
    chk(r1 == 16'h005A, "R4", "mode1 master received", r1, 16'h005A);
    chk(rd_data == 16'h00C3, "R4", "mode1 rd_data", rd_data, 16'h00C3);
    host_read();

    // mode 2, LSB first
    set_mode(1, 0, 0, 1);
    host_write(16'hFF01);
    sel(1); frame(16'h0080, 8, r1); sel(0);
    chk(r1 == 16'h0001, "R6", "lsb-first master received", r1, 16'h0001);
    chk(rd_data == 16'h0080, "R6", "lsb-first rd_data", rd_data, 16'h0080);
    chk(rd_data[15:8] == 8'h00, "R5", "narrow upper byte", rd_data[15:8], 0);
    host_read();

    // mode 3, 16-bit LSB first
    set_mode(1, 1, 1, 1);
    host_write(16'hBEEF);
    sel(1); frame(16'h1234, 16, r1); sel(0);
    chk(r1 == 16'hBEEF, "R5", "wide lsb master received", r1, 16'hBEEF);
    chk(rd_data == 16'h1234, "R5", "wide lsb rd_data", rd_data, 16'h1234);
    host_read();

    // mode 0, 16-bit MSB first
    set_mode(0, 0, 1, 0);
    host_write(16'h8001);
    sel(1); frame(16'h7FFE, 16, r1); sel(0);
    chk(r1 == 16'h8001, "R5", "wide msb master received", r1, 16'h8001);
    chk(rd_data == 16'h7FFE, "R5", "wide msb rd_data", rd_data, 16'h7FFE);
    host_read();

    // back-to-back frames without read or rewrite
    set_mode(0, 1, 0, 0);
    host_write(16'h0066);
    sel(1); frame(16'h0011, 8, r1); frame(16'h0022, 8, r2); sel(0);
    chk(r1 == 16'h0066, "R8", "first frame word", r1, 16'h0066);
    chk(r2 == 16'h0066, "R11", "repeat when txe set", r2, 16'h0066);
    chk(ovr == 1, "R9", "overrun flagged", ovr, 1);
    chk(rd_data == 16'h0011, "R9", "older word kept", rd_data, 16'h0011);
    host_read();
    chk(ovr == 0, "R9", "ovr cleared by read", ovr, 0);

    // aborted frame
    set_mode(0, 0, 0, 0);
    host_write(16'h0099);
    sel(1); frame(16'h00FF, 5, r1); sel(0);
    chk(rxne == 0, "R10", "no rxne after abort", rxne, 0);
    sel(1); frame(16'h004D, 8, r1); sel(0);
    chk(rd_data == 16'h004D, "R10", "restart from bit 0", rd_data, 16'h004D);
    chk(r1 == 16'h0099, "R11", "word resent after abort", r1, 16'h0099);
    host_read();

    // software select
    sw_en = 1; sw_n = 1; cs_n = 1;
    host_write(16'h003E);
    sel(1);
    chk(sdo_oe == 1, "R1", "oe from internal select", sdo_oe, 1);
    frame(16'h00A7, 8, r1); sel(0);
    chk(r1 == 16'h003E, "R1", "sw select master received", r1, 16'h003E);
    chk(rd_data == 16'h00A7, "R1", "sw select rd_data", rd_data, 16'h00A7);
    host_read();
    cs_n = 0; tick(H);
    chk(sdo_oe == 0, "R1", "pin ignored: oe", sdo_oe, 0);
    frame(16'h00FF, 8, r1);
    chk(rxne == 0, "R1", "pin ignored: no frame", rxne, 0);
    cs_n = 1; sw_en = 0; tick(H);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule